// File: doc/BRIEF.md
# HDLC Receive FIFO Pool Controller

This block sits behind an HDLC deframer and holds the received frame octets in a byte FIFO until a host fetches them. The deframer hands over one octet per strobe and, at the closing flag, an end-of-frame strobe together with its CRC, abort and octet-alignment verdicts. The controller stores the octets and writes one status octet after the last data octet of each frame. It reports three receive events in a clear-on-read interrupt status register: message end, every full pool of a long frame, and a frame lost as a whole.

The host reads the octet at the head of the FIFO at any time and pops it with a one-cycle strobe. Popped slots stay reserved until the host issues a release, so a pool that has been read can be handed back in one step. A frame that runs out of space keeps the octets already stored, drops the rest, and says so in its status octet. A frame that finds no space for even its first octet is discarded and reported by its own interrupt bit.

Top module: `rxp_rx_pool`

## Requirements
- R1: After reset the status register reads 0x10 (bit 4 set, all others clear), the interrupt line is high and no octet is readable.
- R2: Stored octets come out in arrival order at `rd_data` while `rd_valid` is high; a pop strobe with no readable octet has no effect.
- R3: A data octet is stored only while the occupancy (unread plus popped but not yet released octets) is below DEPTH-1; `pool_free` returns every popped slot to the free space.
- R4: The status octet is, from bit 7 down: length-valid, no-overflow, CRC error, not-aborted, then four zero bits; a clean frame gives 0xD0, a CRC error 0xF0, an abort 0xC0.
- R5: The length-valid bit (bit 7) is set only when the deframer reports octet alignment and the frame carried at least MIN_LEN octets, dropped octets included.
- R6: Status bit 6 is set each time a frame stores its POOL-th, 2·POOL-th, … octet.
- R7: Status bit 7 is set in the cycle a status octet is written to the FIFO.
- R8: Once an octet of a frame is dropped for lack of space, every later octet of that frame is dropped too, and the frame's status octet has bit 6 clear (0x90 for an otherwise clean frame).
- R9: A frame that stores no octet because of overflow, or that ends with no octet stored while the FIFO is full, writes no status octet and sets status bit 5.
- R10: A status read strobe clears the register at the next edge; an event arriving in that same cycle stays set. Bit 4 is set only by reset.
- R11: The interrupt line is high exactly when any status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Deframer octet strobe |
| in_data | input | 8 | Received octet |
| in_eof | input | 1 | Closing flag seen; never high together with in_valid |
| in_crc_err | input | 1 | CRC mismatch, qualified by in_eof |
| in_abort | input | 1 | Frame aborted, qualified by in_eof |
| in_octet_ok | input | 1 | Frame length was a whole number of octets, qualified by in_eof |
| host_rd | input | 1 | Pop the head octet |
| host_sta_rd | input | 1 | Status register read; clears it |
| pool_free | input | 1 | Release all popped slots |
| rd_data | output | 8 | Head octet of the FIFO |
| rd_valid | output | 1 | At least one unread octet |
| sta0 | output | 8 | Interrupt status register |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with DEPTH=16 and POOL=8 instead of 64 and 32. With these values a 12-octet frame crosses one pool boundary and a 20-octet frame crosses a boundary and overflows, and the FIFO fills after a few dozen cycles. Partial loss, whole-frame loss and the release rule can therefore be reached inside short directed frames. MIN_LEN stays at 3, so the length-valid boundary is exercised with two-octet and three-octet frames.

// File: rtl/rxp_pkg.sv
// Shared constants and types for the receive FIFO pool controller.
// Assumes an 8-bit status register and an 8-bit status octet.
package rxp_pkg;
    localparam int STA_W   = 8;
    localparam int IDX_RME = 7;
    localparam int IDX_RPF = 6;
    localparam int IDX_RFO = 5;
    localparam int IDX_XPR = 4;
    localparam logic [STA_W-1:0] STA_RESET = 8'h10;

    // Status octet written after the last data octet of a frame
    typedef struct packed {
        logic       len_ok;
        logic       no_ovf;
        logic       crc_bad;
        logic       not_abort;
        logic [3:0] zero;
    } rx_stat_t;

    // Receive events raised towards the status register
    typedef struct packed {
        logic rme;
        logic rpf;
        logic rfo;
    } rx_evt_t;
endpackage

// File: rtl/rxp_pool_mem.sv
// Byte FIFO with three pointers: write, read and free.
// Popped slots stay occupied until a release copies the read pointer
// into the free pointer. Assumes DEPTH is a power of two and that the
// producer never pushes when occupancy equals DEPTH.
module rxp_pool_mem #(
    parameter  int DEPTH = 64,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int OW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          pool_free,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [OW-1:0] occ
);
    logic [DW-1:0] mem [DEPTH];
    logic [OW-1:0] wr_ptr;
    logic [OW-1:0] rd_ptr;
    logic [OW-1:0] free_ptr;
    logic          pop_ok;

    // Head view, occupancy and qualified pop
    always_comb begin
        rd_valid = (rd_ptr != wr_ptr);
        rd_data  = mem[rd_ptr[AW-1:0]];
        occ      = wr_ptr - free_ptr;
        pop_ok   = pop && rd_valid;
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr[AW-1:0]] <= push_data;
        end
    end

    // Pointer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            free_ptr <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + OW'(1);
            end
            if (pop_ok) begin
                rd_ptr <= rd_ptr + OW'(1);
            end
            if (pool_free) begin
                free_ptr <= rd_ptr;
            end
        end
    end
endmodule

// File: rtl/rxp_frame_track.sv
// Per-frame bookkeeping: decides whether each octet is stored or
// dropped, counts pool blocks, builds the status octet at end of frame
// and raises the receive events. Assumes in_eof never coincides with
// in_valid and that occ counts unread plus unreleased slots.
module rxp_frame_track
    import rxp_pkg::*;
#(
    parameter  int DEPTH   = 64,
    parameter  int POOL    = 32,
    parameter  int MIN_LEN = 3,
    localparam int OW      = $clog2(DEPTH) + 1,
    localparam int BW      = $clog2(POOL + 1),
    localparam int LW      = $clog2(MIN_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_eof,
    input  logic          in_crc_err,
    input  logic          in_abort,
    input  logic          in_octet_ok,
    input  logic [OW-1:0] occ,
    output logic          push,
    output logic [7:0]    push_data,
    output rx_evt_t       evt
);
    logic [BW-1:0] blk_cnt;
    logic [LW-1:0] len_cnt;
    logic          ovf;
    logic          stored_any;
    logic          room_data;
    logic          room_stat;
    logic          byte_push;
    logic          byte_drop;
    logic          lost_whole;
    logic          stat_push;
    rx_stat_t      stat;

    // Space checks: one slot is always kept back for the status octet
    always_comb begin
        room_data = (occ < OW'(DEPTH - 1));
        room_stat = (occ < OW'(DEPTH));
    end

    // Store or drop decision for the current octet and end of frame
    always_comb begin
        byte_push  = in_valid && !ovf && room_data;
        byte_drop  = in_valid && !byte_push;
        lost_whole = in_eof && !stored_any && (ovf || !room_stat);
        stat_push  = in_eof && !lost_whole;
    end

    // Status octet assembly
    always_comb begin
        stat.len_ok    = in_octet_ok && (len_cnt >= LW'(MIN_LEN));
        stat.no_ovf    = !ovf;
        stat.crc_bad   = in_crc_err;
        stat.not_abort = !in_abort;
        stat.zero      = '0;
    end

    // Write port selection and event strobes
    always_comb begin
        push      = byte_push || stat_push;
        push_data = stat_push ? stat : in_data;
        evt.rme   = stat_push;
        evt.rpf   = byte_push && (blk_cnt == BW'(POOL - 1));
        evt.rfo   = lost_whole;
    end

    // Frame state, cleared at each end of frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_cnt    <= '0;
            len_cnt    <= '0;
            ovf        <= 1'b0;
            stored_any <= 1'b0;
        end else if (in_eof) begin
            blk_cnt    <= '0;
            len_cnt    <= '0;
            ovf        <= 1'b0;
            stored_any <= 1'b0;
        end else begin
            if (in_valid && (len_cnt < LW'(MIN_LEN))) begin
                len_cnt <= len_cnt + LW'(1);
            end
            if (byte_drop) begin
                ovf <= 1'b1;
            end
            if (byte_push) begin
                stored_any <= 1'b1;
                blk_cnt    <= (blk_cnt == BW'(POOL - 1)) ? '0 : blk_cnt + BW'(1);
            end
        end
    end
endmodule

// File: rtl/rxp_irq_reg.sv
// Interrupt status register with clear-on-read; a new event in the
// read cycle survives the clear. The interrupt line ORs all bits.
// Assumes events are single-cycle strobes.
module rxp_irq_reg
    import rxp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  rx_evt_t          evt,
    input  logic             sta_rd,
    output logic [STA_W-1:0] sta,
    output logic             irq
);
    logic [STA_W-1:0] set_mask;

    // Map event strobes onto register bit positions
    always_comb begin
        set_mask          = '0;
        set_mask[IDX_RME] = evt.rme;
        set_mask[IDX_RPF] = evt.rpf;
        set_mask[IDX_RFO] = evt.rfo;
        irq               = |sta;
    end

    // Register update: clear on read, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta <= STA_RESET;
        end else begin
            sta <= (sta_rd ? '0 : sta) | set_mask;
        end
    end
endmodule

// File: rtl/rxp_rx_pool.sv
// Top of the receive FIFO pool controller: frame tracker feeding a
// byte FIFO, plus the interrupt status register. Assumes POOL < DEPTH.
module rxp_rx_pool
    import rxp_pkg::*;
#(
    parameter  int DEPTH   = 64,
    parameter  int POOL    = 32,
    parameter  int MIN_LEN = 3,
    localparam int OW      = $clog2(DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_eof,
    input  logic       in_crc_err,
    input  logic       in_abort,
    input  logic       in_octet_ok,
    input  logic       host_rd,
    input  logic       host_sta_rd,
    input  logic       pool_free,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic [7:0] sta0,
    output logic       irq
);
    logic [OW-1:0] occ;
    logic          push;
    logic [7:0]    push_data;
    rx_evt_t       evt;

    rxp_frame_track #(
        .DEPTH(DEPTH), .POOL(POOL), .MIN_LEN(MIN_LEN)
    ) u_track (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_eof(in_eof),
        .in_crc_err(in_crc_err), .in_abort(in_abort), .in_octet_ok(in_octet_ok),
        .occ(occ), .push(push), .push_data(push_data), .evt(evt)
    );

    rxp_pool_mem #(
        .DEPTH(DEPTH), .DW(8)
    ) u_mem (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(push_data),
        .pop(host_rd), .pool_free(pool_free),
        .rd_data(rd_data), .rd_valid(rd_valid), .occ(occ)
    );

    rxp_irq_reg u_irq (
        .clk(clk), .rst_n(rst_n),
        .evt(evt), .sta_rd(host_sta_rd),
        .sta(sta0), .irq(irq)
    );
endmodule

// File: rtl/rxp_rx_pool_chk.sv
// Property checker for the receive FIFO pool controller, bound to the top.
module rxp_rx_pool_chk #(
    parameter  int DEPTH = 64,
    localparam int OW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [OW-1:0] occ,
    input logic          push,
    input logic [7:0]    sta0,
    input logic          host_sta_rd
);
    // R3: occupancy never exceeds the FIFO size
    assert_occ_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OW'(DEPTH));

    // R7: message end only appears together with a FIFO write
    assert_rme_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sta0[7]) |-> $past(push));

    // R6: pool-full only appears together with a FIFO write
    assert_rpf_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sta0[6]) |-> $past(push));

    // R9: a lost frame writes nothing
    assert_rfo_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sta0[5]) |-> !$past(push));

    // R10: bit 4 is gone after any status read
    assert_xpr_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_sta_rd |=> !sta0[4]);
endmodule

bind rxp_rx_pool rxp_rx_pool_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .occ(occ), .push(push),
    .sta0(sta0), .host_sta_rd(host_sta_rd)
);

// File: tb/sim_rxp_rx_pool.sv
module sim_rxp_rx_pool;
    localparam int CLK_P   = 10;
    localparam int DEPTH   = 16;
    localparam int POOL    = 8;
    localparam int MIN_LEN = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_eof = 1'b0, in_crc_err = 1'b0;
    logic       in_abort = 1'b0, in_octet_ok = 1'b0;
    logic [7:0] in_data = '0;
    logic       host_rd = 1'b0, host_sta_rd = 1'b0, pool_free = 1'b0;
    logic [7:0] rd_data, sta0;
    logic       rd_valid, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    rxp_rx_pool #(.DEPTH(DEPTH), .POOL(POOL), .MIN_LEN(MIN_LEN)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_eof(in_eof),
        .in_crc_err(in_crc_err), .in_abort(in_abort), .in_octet_ok(in_octet_ok),
        .host_rd(host_rd), .host_sta_rd(host_sta_rd), .pool_free(pool_free),
        .rd_data(rd_data), .rd_valid(rd_valid), .sta0(sta0), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    byte unsigned q[$];
    int   held, m_len, m_blk, used;
    bit   m_ovf, m_any, room_d, room_s;
    logic [7:0] m_sta, ev;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); held = 0; m_len = 0; m_blk = 0;
            m_ovf = 0; m_any = 0; m_sta = 8'h10;
        end else begin
            used   = q.size() + held;
            room_d = used < DEPTH - 1;
            room_s = used < DEPTH;
            ev = 8'h00;
            if (pool_free) held = 0;
            if (host_rd && q.size() > 0) begin
                void'(q.pop_front());
                held++;
            end
            if (in_valid) begin
                if (m_len < MIN_LEN) m_len++;
                if (!m_ovf && room_d) begin
                    q.push_back(in_data);
                    m_any = 1;
                    m_blk++;
                    if (m_blk == POOL) begin
                        m_blk = 0;
                        ev[6] = 1'b1;
                    end
                end else begin
                    m_ovf = 1;
                end
            end
            if (in_eof) begin
                if (!m_any && (m_ovf || !room_s)) begin
                    ev[5] = 1'b1;
                end else begin
                    q.push_back({in_octet_ok && (m_len >= MIN_LEN), !m_ovf,
                                 in_crc_err, !in_abort, 4'b0000});
                    ev[7] = 1'b1;
                end
                m_len = 0; m_blk = 0; m_ovf = 0; m_any = 0;
            end
            m_sta = (host_sta_rd ? 8'h00 : m_sta) | ev;
        end
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        string t;
        t = rst_n ? "R2" : "R1";
        chk(rd_valid == (q.size() > 0), t, rd_valid, q.size() > 0);
        if (q.size() > 0) chk(rd_data == q[0], "R2", rd_data, q[0]);
        chk(sta0[7] == m_sta[7], rst_n ? "R7" : "R1", sta0[7], m_sta[7]);
        chk(sta0[6] == m_sta[6], rst_n ? "R6" : "R1", sta0[6], m_sta[6]);
        chk(sta0[5] == m_sta[5], rst_n ? "R9" : "R1", sta0[5], m_sta[5]);
        chk(sta0[4:0] == m_sta[4:0], rst_n ? "R10" : "R1", sta0[4:0], m_sta[4:0]);
        chk(irq == (m_sta != 0), "R11", irq, m_sta != 0);
    end

    task automatic cyc();
        @(posedge clk);
        #1;
        in_valid = 0; in_eof = 0; host_rd = 0; host_sta_rd = 0; pool_free = 0;
        in_crc_err = 0; in_abort = 0; in_octet_ok = 0;
    endtask

    task automatic send_frame(input int n, input int base, input bit crc,
                              input bit ab, input bit oct);
        for (int i = 0; i < n; i++) begin
            in_valid = 1; in_data = 8'(base + i);
            cyc();
        end
        in_eof = 1; in_crc_err = crc; in_abort = ab; in_octet_ok = oct;
        cyc();
    endtask

    task automatic pop_expect(input logic [7:0] exp, input string req);
        chk(rd_valid && rd_data == exp, req, rd_data, exp);
        host_rd = 1;
        cyc();
    endtask

    task automatic pop_data(input int n, input int base);
        for (int i = 0; i < n; i++) pop_expect(8'(base + i), "R2");
    endtask

    task automatic sta_read();
        host_sta_rd = 1;
        cyc();
    endtask

    task automatic release_pool();
        pool_free = 1;
        cyc();
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1;
        repeat (3) cyc();
        // R1: reset state
        chk(sta0 == 8'h10, "R1", sta0, 8'h10);
        chk(irq == 1'b1, "R1", irq, 1);
        chk(rd_valid == 1'b0, "R1", rd_valid, 0);
        rst_n = 1;
        cyc();

        // R4: clean five-octet frame
        send_frame(5, 8'h10, 0, 0, 1);
        chk(sta0[7] == 1'b1, "R7", sta0[7], 1);
        pop_data(5, 8'h10);
        pop_expect(8'hD0, "R4");
        sta_read();
        chk(sta0 == 8'h00 && !irq, "R10", sta0, 0);
        release_pool();

        // R5: length and alignment checks
        send_frame(2, 8'h20, 0, 0, 1);
        pop_data(2, 8'h20);
        pop_expect(8'h50, "R5");
        send_frame(3, 8'h28, 0, 0, 1);
        pop_data(3, 8'h28);
        pop_expect(8'hD0, "R5");
        send_frame(4, 8'h30, 0, 0, 0);
        pop_data(4, 8'h30);
        pop_expect(8'h50, "R5");
        release_pool();
        // R4: CRC error and abort encodings
        send_frame(3, 8'h40, 1, 0, 1);
        pop_data(3, 8'h40);
        pop_expect(8'hF0, "R4");
        send_frame(3, 8'h48, 0, 1, 1);
        pop_data(3, 8'h48);
        pop_expect(8'hC0, "R4");
        sta_read();
        release_pool();

        // R6: long frame crossing one pool boundary
        send_frame(12, 8'h60, 0, 0, 1);
        chk(sta0[6] == 1'b1, "R6", sta0[6], 1);
        pop_data(12, 8'h60);
        pop_expect(8'hD0, "R4");
        sta_read();
        release_pool();

        // R8: partial loss in a 20-octet frame
        send_frame(20, 8'h80, 0, 0, 1);
        chk(sta0[5] == 1'b0, "R8", sta0[5], 0);
        // R9: whole frame lost while full
        send_frame(4, 8'hA0, 0, 0, 1);
        chk(sta0[5] == 1'b1, "R9", sta0[5], 1);
        pop_data(15, 8'h80);
        pop_expect(8'h90, "R8");
        // R2: pop with nothing readable
        host_rd = 1;
        cyc();
        chk(rd_valid == 1'b0, "R2", rd_valid, 0);
        sta_read();
        // R3: popped but unreleased slots still block storage
        send_frame(3, 8'hB0, 0, 0, 1);
        chk(sta0[5] == 1'b1 && rd_valid == 1'b0, "R3", sta0, 8'h20);
        release_pool();
        send_frame(3, 8'hB8, 0, 0, 1);
        pop_data(3, 8'hB8);
        pop_expect(8'hD0, "R3");
        sta_read();
        release_pool();

        // R10: event in the read cycle survives the clear
        in_valid = 1; in_data = 8'hC0; cyc();
        in_eof = 1; in_octet_ok = 1; host_sta_rd = 1; cyc();
        chk(sta0 == 8'h80, "R10", sta0, 8'h80);
        chk(irq == 1'b1, "R11", irq, 1);
        pop_expect(8'hC0, "R2");
        pop_expect(8'h50, "R5");
        sta_read();
        chk(irq == 1'b0, "R11", irq, 0);
        cyc();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule